// File: doc/BRIEF.md
# DRAM Page Idle-Close Tracker

This block sits beside an SDRAM command scheduler and keeps track of which bank holds an open row, and which row that is. Every access presented on the access port is classified in the same cycle as a page hit, a page miss (a different row is open, so precharge then activate) or a closed bank (activate only). Once the access is accepted, the bank is recorded as open with the new row.

A programmable idle timer watches the access stream. When the device has seen no access for the number of clocks chosen by a 4-bit code, the block raises a close request for the banks shown on the open mask. The request stays up until the scheduler acknowledges it. The acknowledgement closes every tracked bank. A precharge-all issued elsewhere clears the tracking at once. The device can be run with two or four banks per row. In two-bank mode the upper bank indices are not tracked.

Top module: `pgidle_top`

## Requirements
- R1: After reset, openMask is all zero and closeReq is low.
- R2: While accValid is high, accResult gives the class of the access in the same cycle: 0 = bank closed, 1 = hit (the bank is open on the same row), 2 = miss (the bank is open on another row), 3 = untracked bank.
- R3: A tracked access sets openMask[accBank] at the next clock edge and stores accRow as that bank's open row.
- R4: With fourBankMode = 0, only banks 0 and 1 are tracked. An access to bank 2 or 3 reports 3, changes no open flag, and openMask[3:2] stays zero. With fourBankMode = 1, all four banks are tracked.
- R5: The idle limit for idleCode[3] = 0 is given by idleCode[2:0]: 0→0, 1→2, 2→4, 3→8, 4→10, 5→12, 6→16, 7→32 clocks.
- R6: Any idleCode with bit 3 set never raises closeReq, and the open banks stay open.
- R7: closeReq rises exactly limit clock edges after the edge that accepted the last access. A code of 0 raises it at the accepting edge itself. Any new access restarts the count.
- R8: closeReq stays high until closeAck. The acknowledgement clears closeReq and every open flag at the next edge. Only one request is raised per idle period.
- R9: A prechargeAll pulse clears every open flag and any pending closeReq at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fourBankMode | input | 1 | 0 = two banks per row, 1 = four banks per row |
| idleCode | input | 4 | Idle timeout code |
| accValid | input | 1 | An access is presented this cycle |
| accBank | input | 2 | Bank index of the access |
| accRow | input | 13 | Row address of the access |
| prechargeAll | input | 1 | A precharge-all was issued to the device |
| closeAck | input | 1 | The scheduler has closed the requested banks |
| accResult | output | 2 | Class of the presented access |
| openMask | output | 4 | One open flag per bank |
| closeReq | output | 1 | Request to precharge the banks on openMask |

## Verification
The assertions assume that closeAck is only driven while closeReq is high. They also assume that idleCode and fourBankMode do not change while an idle count is running. The stimulus keeps to this: it changes the code and the mode only after a precharge-all has cleared all tracking, and it pulses the acknowledgement once, after it has seen the request. The timeout sweep drives every one of the sixteen codes and measures the rise of the request in clock edges from the accepting edge.

// File: rtl/pgidle_pkg.sv
package pgidle_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    RES_CLOSED    = 2'd0,
    RES_HIT       = 2'd1,
    RES_MISS      = 2'd2,
    RES_UNTRACKED = 2'd3
  } accResult_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // drop every open flag this edge
    logic trackAcc;   // current access targets a tracked bank
  } strobe_t;

  // non-linear idle limit, code bit 3 handled by the caller
  function automatic logic [CNT_W-1:0] idleLimit(input logic [2:0] code);
    logic [CNT_W-1:0] lim;
    case (code)
      3'd0: lim = CNT_W'(0);
      3'd1: lim = CNT_W'(2);
      3'd2: lim = CNT_W'(4);
      3'd3: lim = CNT_W'(8);
      3'd4: lim = CNT_W'(10);
      3'd5: lim = CNT_W'(12);
      3'd6: lim = CNT_W'(16);
      default: lim = CNT_W'(32);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/pgidle_ctrl.sv
module pgidle_ctrl
  import pgidle_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fourBankMode,
  input  logic [3:0]        idleCode,
  input  logic              accValid,
  input  logic [BANK_W-1:0] accBank,
  input  logic              prechargeAll,
  input  logic              closeAck,
  input  logic              anyOpenNext,
  output strobe_t           strobe,
  output logic              closeReq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int HALF = NUM_BANKS / 2;

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] cntNext;
  logic             bankInRange;
  logic             fire;
  logic             reqNext;

  always_comb begin
    bankInRange = fourBankMode || (int'(accBank) < HALF);
    strobe.trackAcc = accValid && bankInRange;
    strobe.clearAll = prechargeAll || (closeReq && closeAck);
  end

  // idle cycles since the last accepted access, saturating
  always_comb begin
    if (accValid)              cntNext = '0;
    else if (idleCnt == CNT_MAX) cntNext = idleCnt;
    else                       cntNext = idleCnt + 1'b1;
  end

  always_comb begin
    fire = !idleCode[3] && anyOpenNext && (cntNext == idleLimit(idleCode[2:0]));
    if (strobe.clearAll) reqNext = fire;
    else                 reqNext = closeReq || fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt  <= CNT_MAX;
      closeReq <= 1'b0;
    end else begin
      idleCnt  <= cntNext;
      closeReq <= reqNext;
    end
  end

endmodule

// File: rtl/pgidle_dp.sv
module pgidle_dp
  import pgidle_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fourBankMode,
  input  logic [BANK_W-1:0]    accBank,
  input  logic [ROW_W-1:0]     accRow,
  input  strobe_t              strobe,
  output accResult_e           accResult,
  output logic [NUM_BANKS-1:0] openMask,
  output logic                 anyOpenNext
);

  localparam int HALF = NUM_BANKS / 2;

  logic [NUM_BANKS-1:0] openNext;
  logic [ROW_W-1:0]     rowReg [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitThis;
    logic enabled;
    assign enabled = fourBankMode || (b < HALF);
    assign hitThis = strobe.trackAcc && (int'(accBank) == b);

    always_comb begin
      openNext[b] = (openMask[b] && !strobe.clearAll && enabled) || hitThis;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openMask[b] <= 1'b0;
        rowReg[b]   <= '0;
      end else begin
        openMask[b] <= openNext[b];
        if (hitThis) rowReg[b] <= accRow;
      end
    end
  end

  assign anyOpenNext = |openNext;

  always_comb begin
    if (!strobe.trackAcc)              accResult = RES_UNTRACKED;
    else if (!openMask[accBank])       accResult = RES_CLOSED;
    else if (rowReg[accBank] == accRow) accResult = RES_HIT;
    else                               accResult = RES_MISS;
  end

endmodule

// File: rtl/pgidle_top.sv
module pgidle_top
  import pgidle_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fourBankMode,
  input  logic [3:0]           idleCode,
  input  logic                 accValid,
  input  logic [BANK_W-1:0]    accBank,
  input  logic [ROW_W-1:0]     accRow,
  input  logic                 prechargeAll,
  input  logic                 closeAck,
  output logic [1:0]           accResult,
  output logic [NUM_BANKS-1:0] openMask,
  output logic                 closeReq
);

  strobe_t    strobe;
  logic       anyOpenNext;
  accResult_e resEnum;

  pgidle_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .fourBankMode(fourBankMode), .idleCode(idleCode),
    .accValid(accValid), .accBank(accBank), .prechargeAll(prechargeAll),
    .closeAck(closeAck), .anyOpenNext(anyOpenNext), .strobe(strobe),
    .closeReq(closeReq)
  );

  pgidle_dp #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .fourBankMode(fourBankMode), .accBank(accBank),
    .accRow(accRow), .strobe(strobe), .accResult(resEnum),
    .openMask(openMask), .anyOpenNext(anyOpenNext)
  );

  assign accResult = resEnum;

endmodule

// File: rtl/pgidle_chk.sv
module pgidle_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int HALF = NUM_BANKS / 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 fourBankMode,
  input logic [3:0]           idleCode,
  input logic                 accValid,
  input logic [BANK_W-1:0]    accBank,
  input logic                 prechargeAll,
  input logic                 closeAck,
  input logic [NUM_BANKS-1:0] openMask,
  input logic                 closeReq
);

  AST_TRACK_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    accValid && (fourBankMode || int'(accBank) < HALF) |=> openMask[$past(accBank)]); // R3

  AST_TWO_BANK_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !fourBankMode |=> (openMask >> HALF) == '0); // R4

  AST_NO_INF_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(closeReq) |-> !$past(idleCode[3])); // R6

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    closeReq && !closeAck && !prechargeAll |=> closeReq); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    closeReq && closeAck && !accValid |=> openMask == '0 && !closeReq); // R8

  AST_PALL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    prechargeAll && !accValid |=> openMask == '0 && !closeReq); // R9

endmodule

bind pgidle_top pgidle_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .fourBankMode(fourBankMode), .idleCode(idleCode),
  .accValid(accValid), .accBank(accBank), .prechargeAll(prechargeAll),
  .closeAck(closeAck), .openMask(openMask), .closeReq(closeReq)
);

// File: tb/sim_pgidle_top.sv
`timescale 1ns/1ps
module sim_pgidle_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fourBankMode = 1'b1;
  logic [3:0]  idleCode = 4'h8;
  logic        accValid = 1'b0;
  logic [1:0]  accBank = '0;
  logic [12:0] accRow = '0;
  logic        prechargeAll = 1'b0;
  logic        closeAck = 1'b0;
  logic [1:0]  accResult;
  logic [3:0]  openMask;
  logic        closeReq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pgidle_top u0 (
    .clk(clk), .rstN(rstN), .fourBankMode(fourBankMode), .idleCode(idleCode),
    .accValid(accValid), .accBank(accBank), .accRow(accRow),
    .prechargeAll(prechargeAll), .closeAck(closeAck), .accResult(accResult),
    .openMask(openMask), .closeReq(closeReq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected idle limit from the R5 table, -1 for infinite (R6)
  function automatic int expLimit(input int code);
    int t[8] = '{0, 2, 4, 8, 10, 12, 16, 32};
    if (code >= 8) return -1;
    return t[code];
  endfunction

  task automatic access(input int bank, input int row, input int expRes, input string req);
    @(negedge clk);
    accValid = 1'b1; accBank = 2'(bank); accRow = 13'(row);
    #1 check(req, int'(accResult), expRes);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic pulseAll();
    @(negedge clk); prechargeAll = 1'b1;
    @(negedge clk); prechargeAll = 1'b0;
  endtask

  // edges from accepting edge to closeReq rise, or -1 within maxEdges
  task automatic measure(input int maxEdges, output int edges);
    edges = -1;
    for (int k = 0; k <= maxEdges; k++) begin
      if (closeReq) begin edges = k; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    int got;
    bit refire;
    repeat (3) @(negedge clk);
    check("R1 openMask", int'(openMask), 0);
    check("R1 closeReq", int'(closeReq), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 R6 R7 R8: sweep every idle code
    for (int c = 0; c < 16; c++) begin
      pulseAll();
      idleCode = 4'(c);
      access(1, c, 0, "R2 closed");
      measure(45, got);
      check($sformatf("R5 R6 R7 code %0d", c), got, expLimit(c));
      if (got >= 0) begin
        repeat (3) @(negedge clk);
        check("R8 hold", int'(closeReq), 1);
        closeAck = 1'b1;
        @(negedge clk); closeAck = 1'b0;
        check("R8 ack mask", int'(openMask), 0);
        check("R8 ack req", int'(closeReq), 0);
        refire = 1'b0;
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          if (closeReq) refire = 1'b1;
        end
        check("R8 once", int'(refire), 0);
      end else begin
        check("R6 stays open", int'(openMask), 2);
      end
    end

    // R7 restart by a new access
    pulseAll();
    idleCode = 4'd3;
    access(0, 7, 0, "R2 closed");
    repeat (5) @(negedge clk);
    check("R7 early", int'(closeReq), 0);
    access(0, 7, 1, "R2 hit");
    measure(45, got);
    check("R7 restart", got, 8);
    closeAck = 1'b1; @(negedge clk); closeAck = 1'b0;

    // R2 R3 R4 classification in both modes, idle closing off
    for (int m = 0; m < 2; m++) begin
      pulseAll();
      fourBankMode = m[0];
      idleCode = 4'hF;
      pulseAll();
      for (int b = 0; b < 4; b++) begin
        if (m == 0 && b >= 2) begin
          access(b, 5, 3, "R4 untracked");
          check("R4 no flag", int'(openMask[3:2]), 0);
        end else begin
          access(b, 5, 0, "R2 closed");
          check("R3 flag", int'(openMask[b]), 1);
          access(b, 5, 1, "R2 hit");
          access(b, 9, 2, "R2 miss");
          access(b, 9, 1, "R3 row stored");
        end
      end
      check("R4 mask", int'(openMask), (m == 0) ? 3 : 15);
    end

    // R9 precharge-all
    pulseAll();
    check("R9 clear", int'(openMask), 0);
    access(3, 9, 0, "R9 closed after");

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule